// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with no turnaround bubbles. Every control input is captured on the rising clock edge. A command edge loads an address and picks the access type. Read data comes straight out of the array in the cycle that follows that edge, with no output register in the path. Write data is taken one edge after its command, so a read or write command can be issued on every edge with no idle cycle between them.

A two-bit burst counter lets one loaded address serve four consecutive accesses. Each advance edge steps only the two lowest address bits, in linear or XOR-interleaved order, and the address wraps after four steps. The output port is a data vector plus a drive-enable, which stands in for a tri-state bus. The drive-enable follows an asynchronous output-enable input. A clock-enable input freezes the whole block on any edge where it is high. Depth and word layout (lane count and lane width) are parameters.

Top module: `fts_sram`

## Requirements
- R1: After synchronous reset no access is active, `rdata_drv` is 0 and `rdata` is all zeros.
- R2: On an edge with `cen_n` high, every internal register keeps its value: the loaded address, the access type, the burst position and any write still waiting for data. A command presented on such an edge is ignored.
- R3: A new access starts on an edge where `cen_n`=0 and `ld_n`=0 and the chip is selected, that is `cs1_n`=0, `cs2`=1 and `cs3_n`=0. The access is a read when `we_n`=1 and a write when `we_n`=0, and `addr` is captured on that edge. If any one of the three selects is inactive, no access starts.
- R4: A write's data (`wdata`, `bw_n`) is sampled on the next enabled edge after its command, and another command may be registered on that same edge.
- R5: On a write, lane i (bits i*BYTE_W+BYTE_W-1 down to i*BYTE_W) is stored only when `bw_n[i]`=0. Lanes whose `bw_n` bit is 1 keep their earlier contents.
- R6: During a read access, `rdata` shows the word at the current burst address immediately after the edge that set that address. `rdata_drv` is 1 only while `oe_n`=0, and it follows `oe_n` without waiting for a clock edge.
- R7: While a write access is current, or after a deselect edge (`ld_n`=0 with the chip not selected), `rdata_drv` is 0 and `rdata` is zero, whatever the level of `oe_n`.
- R8: An enabled edge with `ld_n`=1 during an access moves to the next burst beat. Only address bits 1:0 change, and after four beats the sequence returns to the loaded address.
- R9: If `burst_mode` is 0 at load, beat n uses low bits (start + n) mod 4.
- R10: If `burst_mode` is 1 at load, beat n uses low bits start XOR n.
- R11: On advance edges the levels of `we_n` and the chip selects are ignored, and the access type captured at load holds for the whole burst.
- R12: Advance edges after a deselect leave the block deselected: nothing is written and nothing is driven until a fresh load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low: load a new access; high: advance the burst |
| we_n | input | 1 | Access type at load: 0 write, 1 read |
| bw_n | input | BYTES | Per-lane write selects, active low |
| burst_mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTES*BYTE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | BYTES*BYTE_W | Read data, zero when not driven |
| rdata_drv | output | 1 | Output drive enable |

## Verification
Read data for a load or advance edge appears in the same cycle that edge opens, because the only register on the path is the address. The bench therefore drives inputs 1 ns after a rising edge, waits for the next rising edge, and samples 1 ns later, before it drives anything new. Write data counts as stored one edge after its command. Stored data is only checked by a later read command, which shows the word in the cycle after that read's own edge. The drive-enable has no register behind its output-enable path, so the output-enable checks change `oe_n` mid-cycle and sample 1 ns later, with no clock edge in between.

// File: rtl/fts_pkg.sv
package fts_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_ord_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_DESEL,
        OP_READ,
        OP_WRITE,
        OP_ADV
    } op_e;

    typedef struct packed {
        logic       active;
        logic       is_wr;
        burst_ord_e ord;
    } acc_t;

    function automatic op_e decode_op(logic cen_n, logic sel, logic ld_n, logic we_n);
        op_e op;
        if (cen_n)
            op = OP_IDLE;
        else if (!ld_n)
            op = sel ? (we_n ? OP_READ : OP_WRITE) : OP_DESEL;
        else
            op = OP_ADV;
        return op;
    endfunction

    function automatic logic [1:0] beat_offset(logic [1:0] start, logic [1:0] beat,
                                               burst_ord_e ord);
        return (ord == ORD_XOR) ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       step,
    output logic [1:0] beat
);

    always_ff @(posedge clk) begin
        if (rst)
            beat <= 2'd0;
        else if (clr)
            beat <= 2'd0;
        else if (step)
            beat <= beat + 2'd1;
    end

    // R8: each advance moves exactly one beat, wrapping modulo 4
    p_beat_step_r8: assert property (@(posedge clk) disable iff (rst)
        (step && !clr) |=> (beat == $past(beat) + 2'd1));

    // R3: a load restarts the burst at beat zero
    p_beat_clear_r3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (beat == 2'd0));

endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
    import fts_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              ld_n,
    input  logic              we_n,
    input  logic              burst_mode,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc,
    output logic [ADDR_W-1:0] base,
    output logic [1:0]        beat
);

    logic sel;
    op_e  op;
    logic load_edge;
    logic adv_edge;

    assign sel       = !cs1_n && cs2 && !cs3_n;
    assign op        = decode_op(cen_n, sel, ld_n, we_n);
    assign load_edge = (op == OP_READ) || (op == OP_WRITE) || (op == OP_DESEL);
    assign adv_edge  = (op == OP_ADV) && acc.active;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '{active: 1'b0, is_wr: 1'b0, ord: ORD_LINEAR};
            base <= '0;
        end else begin
            unique case (op)
                OP_READ, OP_WRITE: begin
                    acc.active <= 1'b1;
                    acc.is_wr  <= (op == OP_WRITE);
                    acc.ord    <= burst_mode ? ORD_XOR : ORD_LINEAR;
                    base       <= addr;
                end
                OP_DESEL: acc.active <= 1'b0;
                default: ;
            endcase
        end
    end

    fts_burst_ctr u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (load_edge),
        .step (adv_edge),
        .beat (beat)
    );

    // R2: a disabled edge changes no state
    p_freeze_r2: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(acc) && $stable(base) && $stable(beat)));

    // R11: advance edges keep the access type and loaded address
    p_type_held_r11: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && ld_n) |=> ($stable(acc.is_wr) && $stable(base)));

    // R7: a deselect edge ends the access
    p_desel_r7: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !ld_n && !sel) |=> !acc.active);

    // R12: advancing while deselected never revives an access
    p_stay_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && ld_n && !acc.active) |=> !acc.active);

endmodule

// File: rtl/fts_array.sv
module fts_array #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [BYTES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    output logic [BYTES*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !bw_n[g])
                lane_mem[addr] <= wdata[g*BYTE_W +: BYTE_W];
        end

        assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[addr];
    end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cen_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    ld_n,
    input  logic                    we_n,
    input  logic [BYTES-1:0]        bw_n,
    input  logic                    burst_mode,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [BYTES*BYTE_W-1:0] rdata,
    output logic                    rdata_drv
);

    localparam int DATA_W = BYTES * BYTE_W;

    acc_t              acc;
    logic [ADDR_W-1:0] base;
    logic [1:0]        beat;
    logic [ADDR_W-1:0] cur_addr;
    logic              wr_fire;
    logic              rd_live;
    logic [DATA_W-1:0] arr_q;

    fts_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cen_n      (cen_n),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .ld_n       (ld_n),
        .we_n       (we_n),
        .burst_mode (burst_mode),
        .addr       (addr),
        .acc        (acc),
        .base       (base),
        .beat       (beat)
    );

    assign cur_addr = {base[ADDR_W-1:2], beat_offset(base[1:0], beat, acc.ord)};

    // the current write beat takes its data on the next enabled edge
    assign wr_fire = !cen_n && acc.active && acc.is_wr;

    fts_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
        .clk   (clk),
        .we    (wr_fire),
        .bw_n  (bw_n),
        .addr  (cur_addr),
        .wdata (wdata),
        .rdata (arr_q)
    );

    assign rd_live   = acc.active && !acc.is_wr;
    assign rdata_drv = rd_live && !oe_n;
    assign rdata     = rdata_drv ? arr_q : '0;

    // R7: never drive during a write access
    p_wr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (acc.active && acc.is_wr) |-> (!rdata_drv && rdata == '0));

    // R6: output enable high forbids drive
    p_oe_gate_r6: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rdata_drv);

    // R8: advance edges only touch address bits 1:0
    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && ld_n && acc.active) |=> $stable(cur_addr[ADDR_W-1:2]));

    // R1: nothing is driven right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !rdata_drv);

endmodule

// File: tb/tb_fts_sram.sv
module tb_fts_sram;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam logic [2:0] CS_ON  = 3'b010;  // {cs1_n, cs2, cs3_n}
    localparam logic [2:0] CS_OFF = 3'b101;

    logic          clk = 1'b0;
    logic          rst;
    logic          cen_n, cs1_n, cs2, cs3_n, ld_n, we_n, burst_mode, oe_n;
    logic [NB-1:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    int n_chk  = 0;
    int n_fail = 0;
    logic [DW-1:0] ref_mem [1 << AW];

    always #2 clk = ~clk;

    fts_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) dut (
        .clk(clk), .rst(rst), .cen_n(cen_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .burst_mode(burst_mode), .addr(addr),
        .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_drv(rdata_drv)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(logic cen, logic [2:0] cs, logic ld, logic we, logic mode,
                         logic [AW-1:0] a, logic [NB-1:0] bw, logic [DW-1:0] wd);
        cen_n = cen; {cs1_n, cs2, cs3_n} = cs; ld_n = ld; we_n = we;
        burst_mode = mode; addr = a; bw_n = bw; wdata = wd;
    endtask

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] s, int n, logic mode);
        logic [1:0] nb = n[1:0];
        logic [1:0] lo = mode ? (s[1:0] ^ nb) : (s[1:0] + nb);
        return {s[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] pat(int k);
        return {4'(k), 32'h5A00_0000 + 32'(k * 32'h0101_0307)};
    endfunction

    task automatic burst_wr(logic [AW-1:0] s, logic mode, int seed, string tag);
        drive(0, CS_ON, 0, 0, mode, s, '0, '0);
        tick();
        for (int i = 0; i < 4; i++) begin
            if (i < 3) drive(0, CS_OFF, 1, 1, 1'b0, 8'hFF, '0, pat(seed + i));  // R11: we_n/cs ignored
            else       drive(0, CS_OFF, 0, 1, 1'b0, 8'h00, '0, pat(seed + i));
            tick();
            ref_mem[beat_addr(s, i, mode)] = pat(seed + i);
            chk({tag, " no drive in write burst R7"}, 64'(rdata_drv), 64'd0);
        end
    endtask

    task automatic burst_rd(logic [AW-1:0] s, logic mode, string tag);
        drive(0, CS_ON, 0, 1, mode, s, '1, '0);
        tick();
        chk({tag, " beat0 R6"}, 64'(rdata), 64'(ref_mem[s]));
        for (int i = 1; i < 5; i++) begin
            drive(0, CS_OFF, 1, 0, ~mode, 8'hFF, '0, '1);  // R11: type held
            tick();
            chk({tag, " beat R8"}, 64'(rdata), 64'(ref_mem[beat_addr(s, i, mode)]));
            chk({tag, " drive R11"}, 64'(rdata_drv), 64'd1);
        end
        drive(0, CS_OFF, 0, 1, 1'b0, '0, '1, '0);
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(0, CS_OFF, 0, 1, 0, '0, '1, '0);
        oe_n = 1'b0;
        tick(); tick();
        rst = 1'b0;
        chk("reset drive R1", 64'(rdata_drv), 64'd0);
        chk("reset data R1", 64'(rdata), 64'd0);
    endtask

    task automatic t_back_to_back();
        drive(0, CS_ON, 0, 0, 0, 8'h15, '0, '0);                  // write cmd A
        tick();
        chk("write cycle quiet R7", 64'(rdata_drv), 64'd0);
        drive(0, CS_ON, 0, 1, 0, 8'h15, '0, 36'h9_1234_5678);     // data A + read A (R4)
        tick();
        ref_mem[8'h15] = 36'h9_1234_5678;
        chk("read after write R4", 64'(rdata), 64'h9_1234_5678);
        chk("read drive R6", 64'(rdata_drv), 64'd1);
        drive(0, CS_ON, 0, 0, 0, 8'h16, '0, '1);                  // write cmd B right after read
        tick();
        chk("read->write quiet R7", 64'(rdata_drv), 64'd0);
        drive(0, CS_ON, 0, 1, 0, 8'h16, '0, 36'hA_0F0F_F0F0);     // data B + read B
        tick();
        ref_mem[8'h16] = 36'hA_0F0F_F0F0;
        chk("write then read new R3", 64'(rdata), 64'hA_0F0F_F0F0);
        drive(0, CS_ON, 0, 1, 0, 8'h15, '1, '0);
        tick();
        chk("read A again R3", 64'(rdata), 64'(ref_mem[8'h15]));
    endtask

    task automatic t_byte_mask();
        logic [DW-1:0] nw = 36'h1_ABCD_EF01;
        drive(0, CS_ON, 0, 0, 0, 8'h15, '0, '0);
        tick();
        drive(0, CS_OFF, 0, 1, 0, '0, 4'b1010, nw);               // lanes 0 and 2
        tick();
        for (int g = 0; g < NB; g++)
            if (g == 0 || g == 2) ref_mem[8'h15][g*BW +: BW] = nw[g*BW +: BW];
        drive(0, CS_ON, 0, 1, 0, 8'h15, '1, '0);
        tick();
        chk("byte mask merge R5", 64'(rdata), 64'(ref_mem[8'h15]));
    endtask

    task automatic t_drive_rules();
        drive(0, CS_ON, 0, 1, 0, 8'h16, '1, '0);
        tick();
        chk("oe low drives R6", 64'(rdata_drv), 64'd1);
        oe_n = 1'b1; #1;
        chk("oe high async R6", 64'(rdata_drv), 64'd0);
        chk("oe high zero data R6", 64'(rdata), 64'd0);
        oe_n = 1'b0; #1;
        chk("oe low again R6", 64'(rdata), 64'(ref_mem[8'h16]));
        drive(0, CS_OFF, 0, 1, 0, 8'h16, '1, '0);
        tick();
        chk("deselect stops drive R7", 64'(rdata_drv), 64'd0);
        drive(0, 3'b011, 0, 1, 0, 8'h16, '1, '0);                 // cs3_n inactive
        tick();
        chk("cs3_n high no access R3", 64'(rdata_drv), 64'd0);
        drive(0, 3'b000, 0, 1, 0, 8'h16, '1, '0);                 // cs2 inactive
        tick();
        chk("cs2 low no access R3", 64'(rdata_drv), 64'd0);
        drive(0, 3'b110, 0, 1, 0, 8'h16, '1, '0);                 // cs1_n inactive
        tick();
        chk("cs1_n high no access R3", 64'(rdata_drv), 64'd0);
    endtask

    task automatic t_bursts();
        burst_wr(8'h22, 1'b0, 10, "lin wr");
        burst_rd(8'h22, 1'b0, "lin rd R9");
        burst_wr(8'h41, 1'b1, 20, "xor wr");
        burst_rd(8'h41, 1'b1, "xor rd R10");
        burst_rd(8'h40, 1'b0, "xor placement R10");
        burst_wr(8'h30, 1'b0, 30, "pre wr");
    endtask

    task automatic t_clock_enable();
        drive(0, CS_ON, 0, 1, 0, 8'h22, '1, '0);
        tick();
        drive(1, CS_ON, 1, 1, 0, 8'h41, '1, '0);
        tick();
        chk("hold on advance R2", 64'(rdata), 64'(ref_mem[8'h22]));
        drive(1, CS_ON, 0, 1, 0, 8'h41, '1, '0);
        tick();
        chk("ignored load R2", 64'(rdata), 64'(ref_mem[8'h22]));
        drive(0, CS_OFF, 1, 1, 0, 8'h00, '1, '0);
        tick();
        chk("resume beat R2", 64'(rdata), 64'(ref_mem[8'h23]));
        drive(0, CS_ON, 0, 0, 0, 8'h30, '0, '0);                  // write cmd
        tick();
        drive(1, CS_ON, 0, 1, 0, 8'h31, '0, 36'hF_FFFF_0000);     // frozen, junk data
        tick();
        chk("pending write held R2", 64'(rdata_drv), 64'd0);
        drive(0, CS_ON, 0, 1, 0, 8'h30, '0, 36'h3_3333_CCCC);
        tick();
        ref_mem[8'h30] = 36'h3_3333_CCCC;
        chk("held write lands R2", 64'(rdata), 64'h3_3333_CCCC);
        drive(0, CS_ON, 0, 1, 0, 8'h31, '1, '0);
        tick();
        chk("junk not written R2", 64'(rdata), 64'(ref_mem[8'h31]));
    endtask

    task automatic t_adv_after_desel();
        drive(0, CS_ON, 0, 1, 0, 8'h30, '1, '0);
        tick();
        drive(0, CS_OFF, 0, 1, 0, 8'h30, '1, '0);
        tick();
        for (int i = 0; i < 3; i++) begin
            drive(0, CS_ON, 1, 0, 0, 8'h30, '0, 36'hE_EEEE_EEEE);
            tick();
            chk("advance after deselect quiet R12", 64'(rdata_drv), 64'd0);
        end
        drive(0, CS_OFF, 0, 1, 0, '0, '1, '0);
        tick();
        burst_rd(8'h30, 1'b0, "unchanged R12");
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        t_reset();
        t_back_to_back();
        t_byte_mask();
        t_drive_rules();
        t_bursts();
        t_clock_enable();
        t_adv_after_desel();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule